// File: doc/BRIEF.md
# IDE Programmed-I/O Cycle Timing Generator

This block sequences a single programmed-I/O transfer on an IDE-style parallel bus. A host-side requester asks for one access at a time. Each request gives an address class (data port, or command/control port), a direction and, for writes, the data word. The block then drives an address-valid qualifier, a read or write strobe and a done pulse. All lengths are counted in clocks. Each access has three phases: setup (address valid, strobe idle), active (strobe asserted) and hold (strobe released, address still valid).

The phase lengths come from two 8-bit timing bytes. One serves data-port accesses and the other serves command/control-port accesses, and both attached drives use the same pair. Each byte packs three small codes that map onto nonlinear clock counts. A mode byte selects whether the device ready line (IORDY) may stretch the active phase. It also selects whether data-port cycles are 8 bits wide instead of 16. Command/control-port cycles always carry only the low byte. The timing and mode bytes are loaded through a small write port and come up with usable defaults after reset.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset the block is idle: ready high, address-valid, both strobes, data-enable and done low, read data zero. The data timing byte is 0xF5, the command timing byte is 0xDE, IORDY stretching is off and data-port cycles are 16 bits wide.
- R2: The setup phase lasts (timing bits 7:6) + 1 clocks, so 1 to 4. It starts on the clock after the accepting edge, with address-valid high and no strobe.
- R3: The active phase asserts exactly one strobe: the read strobe for reads, the write strobe for writes. For codes 0..7 in timing bits 2:0 it lasts 2, 3, 4, 5, 6, 8, 12 and 16 clocks.
- R4: The hold phase keeps address-valid high with both strobes low. For codes 0..7 in timing bits 5:3 it lasts 1, 2, 3, 4, 5, 6, 8 and 12 clocks.
- R5: A request with the class input low (data port) uses the data timing byte. A request with the class input high (command/control port) uses the command timing byte. The class is shown on the class-select output for the whole access.
- R6: Phases run strictly setup, active, hold. Done is high for exactly one clock, the last hold clock. Ready is low from the first setup clock through the last hold clock and high again on the next clock, so no request is taken while an access is in flight.
- R7: With IORDY stretching enabled, a low IORDY seen on the last active clock holds the strobe until the first clock edge that sees IORDY high. With stretching disabled, IORDY has no effect.
- R8: Read data is captured from the bus on the edge that ends the active phase. It is visible from the first hold clock and does not change at any other time. In an 8-bit access the upper byte of the captured value is zero.
- R9: For writes the bus drive enable is high for the whole access (setup, active and hold). The driven word is the request data, with the upper byte forced to zero in an 8-bit access. For reads the enable stays low.
- R10: The phase lengths are taken at the accepting edge. A timing-byte write during an access does not alter that access.
- R11: A configuration write with selector 0 loads the data timing byte and selector 1 loads the command timing byte. Selector 2 loads the mode byte: bit 0 enables IORDY stretching and bit 1 selects 8-bit data-port cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration target: 0 data timing, 1 command timing, 2 mode |
| cfg_data_i | input | 8 | Configuration byte |
| req_valid_i | input | 1 | Access request, taken on an edge where ready is high |
| req_cmd_i | input | 1 | Address class: 0 data port, 1 command/control port |
| req_write_i | input | 1 | 1 for a write access, 0 for a read |
| req_wdata_i | input | DW | Write data |
| req_ready_o | output | 1 | Idle and able to take a request |
| iordy_i | input | 1 | Device ready line |
| dd_i | input | DW | Bus data from the device |
| dd_o | output | DW | Bus data to the device |
| dd_oe_o | output | 1 | Bus data drive enable |
| addr_valid_o | output | 1 | Address/chip-select qualifier for the access |
| cmd_sel_o | output | 1 | Class of the access in flight |
| rd_strobe_o | output | 1 | Read strobe (active high) |
| wr_strobe_o | output | 1 | Write strobe (active high) |
| done_o | output | 1 | Last clock of the access |
| rdata_o | output | DW | Captured read data |

## Verification
Outputs come from registered phase state, so each access starts on the clock after the accepting edge. The bench raises a request just after a falling edge and then samples every following falling edge. It counts setup, active and hold clocks, comparing them with lengths computed from its own copy of the timing bytes. It checks done only on the final hold sample and ready on the sample just after it. Read data is due one clock after the last strobe sample, so the bench checks it on the first hold sample and then changes the bus value to show that nothing is captured later. IORDY is released on a chosen strobe sample, which fixes the expected active length at that sample count.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

  localparam int TB_W  = 8;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } pio_phase_e;

  typedef enum logic [1:0] {
    CFG_DATA_TIM = 2'd0,
    CFG_CMD_TIM  = 2'd1,
    CFG_MODE     = 2'd2
  } cfg_sel_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup_len;
    logic [CNT_W-1:0] active_len;
    logic [CNT_W-1:0] hold_len;
  } phase_len_t;

  function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
    return CNT_W'(code) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] hold_clocks(input logic [2:0] code);
    logic [CNT_W-1:0] v;
    unique case (code)
      3'd6:    v = CNT_W'(8);
      3'd7:    v = CNT_W'(12);
      default: v = CNT_W'(code) + CNT_W'(1);
    endcase
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] active_clocks(input logic [2:0] code);
    logic [CNT_W-1:0] v;
    unique case (code)
      3'd5:    v = CNT_W'(8);
      3'd6:    v = CNT_W'(12);
      3'd7:    v = CNT_W'(16);
      default: v = CNT_W'(code) + CNT_W'(2);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import pio_timing_pkg::*;
#(
  parameter logic [TB_W-1:0] DATA_TIM_RST = 8'hF5,
  parameter logic [TB_W-1:0] CMD_TIM_RST  = 8'hDE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_i,
  input  logic [1:0]      cfg_sel_i,
  input  logic [TB_W-1:0] cfg_data_i,
  output logic [TB_W-1:0] data_tim_o,
  output logic [TB_W-1:0] cmd_tim_o,
  output logic            iordy_en_o,
  output logic            byte_mode_o
);

  logic [TB_W-1:0] data_tim_q, cmd_tim_q;
  logic            iordy_en_q, byte_mode_q;
  logic            data_en, cmd_en, mode_en;
  logic            unused_cfg_bits;

  assign unused_cfg_bits = ^cfg_data_i[TB_W-1:2];

  always_comb begin
    data_en = cfg_wr_i && (cfg_sel_i == CFG_DATA_TIM);
    cmd_en  = cfg_wr_i && (cfg_sel_i == CFG_CMD_TIM);
    mode_en = cfg_wr_i && (cfg_sel_i == CFG_MODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_tim_q  <= DATA_TIM_RST;
      cmd_tim_q   <= CMD_TIM_RST;
      iordy_en_q  <= 1'b0;
      byte_mode_q <= 1'b0;
    end else begin
      if (data_en) data_tim_q <= cfg_data_i;
      if (cmd_en)  cmd_tim_q  <= cfg_data_i;
      if (mode_en) begin
        iordy_en_q  <= cfg_data_i[0];
        byte_mode_q <= cfg_data_i[1];
      end
    end
  end

  assign data_tim_o  = data_tim_q;
  assign cmd_tim_o   = cmd_tim_q;
  assign iordy_en_o  = iordy_en_q;
  assign byte_mode_o = byte_mode_q;

endmodule

// File: rtl/pio_phase_decode.sv
module pio_phase_decode
  import pio_timing_pkg::*;
(
  input  logic [TB_W-1:0] tim_i,
  output phase_len_t      len_o
);

  always_comb begin
    len_o.setup_len  = setup_clocks(tim_i[7:6]);
    len_o.hold_len   = hold_clocks(tim_i[5:3]);
    len_o.active_len = active_clocks(tim_i[2:0]);
  end

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_timing_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic          req_cmd_i,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          req_narrow_i,
  input  phase_len_t    len_i,
  input  logic          iordy_en_i,
  input  logic          iordy_i,
  input  logic [DW-1:0] dd_i,
  output logic          ready_o,
  output logic          addr_valid_o,
  output logic          cmd_sel_o,
  output logic          rd_strobe_o,
  output logic          wr_strobe_o,
  output logic [DW-1:0] dd_o,
  output logic          dd_oe_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);

  localparam int NW = 8;

  pio_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_len_q, hold_len_q;
  logic             cmd_q, write_q, narrow_q;
  logic [DW-1:0]    wdata_q, wdata_d;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             accept, cap_en, rd_cap_en, last_clk, stall;

  function automatic logic [DW-1:0] narrow_fix(input logic [DW-1:0] w, input logic n);
    return n ? {{(DW-NW){1'b0}}, w[NW-1:0]} : w;
  endfunction

  assign last_clk = (cnt_q == '0);
  assign stall    = iordy_en_i && !iordy_i;
  assign accept   = (phase_q == PH_IDLE) && req_valid_i;
  assign cap_en   = accept;

  // next-state logic
  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    rd_cap_en = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid_i) begin
          phase_d = PH_SETUP;
          cnt_d   = len_i.setup_len - CNT_W'(1);
        end
      end
      PH_SETUP: begin
        if (last_clk) begin
          phase_d = PH_ACTIVE;
          cnt_d   = act_len_q - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_ACTIVE: begin
        if (last_clk) begin
          if (!stall) begin
            phase_d   = PH_HOLD;
            cnt_d     = hold_len_q - CNT_W'(1);
            rd_cap_en = !write_q;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (last_clk) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q - CNT_W'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    wdata_d = narrow_fix(req_wdata_i, req_narrow_i);
    rdata_d = narrow_fix(dd_i, narrow_q);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // request snapshot, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_len_q  <= '0;
      hold_len_q <= '0;
      cmd_q      <= 1'b0;
      write_q    <= 1'b0;
      narrow_q   <= 1'b0;
      wdata_q    <= '0;
    end else if (cap_en) begin
      act_len_q  <= len_i.active_len;
      hold_len_q <= len_i.hold_len;
      cmd_q      <= req_cmd_i;
      write_q    <= req_write_i;
      narrow_q   <= req_narrow_i;
      wdata_q    <= wdata_d;
    end
  end

  // read capture at the edge that ends the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_cap_en) rdata_q <= rdata_d;
  end

  always_comb begin
    ready_o      = (phase_q == PH_IDLE);
    addr_valid_o = (phase_q != PH_IDLE);
    cmd_sel_o    = addr_valid_o && cmd_q;
    rd_strobe_o  = (phase_q == PH_ACTIVE) && !write_q;
    wr_strobe_o  = (phase_q == PH_ACTIVE) && write_q;
    dd_oe_o      = addr_valid_o && write_q;
    dd_o         = dd_oe_o ? wdata_q : '0;
    done_o       = (phase_q == PH_HOLD) && last_clk;
    rdata_o      = rdata_q;
  end

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_timing_pkg::*;
#(
  parameter int               DW           = 16,
  parameter logic [TB_W-1:0]  DATA_TIM_RST = 8'hF5,
  parameter logic [TB_W-1:0]  CMD_TIM_RST  = 8'hDE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_i,
  input  logic [1:0]      cfg_sel_i,
  input  logic [TB_W-1:0] cfg_data_i,
  input  logic            req_valid_i,
  input  logic            req_cmd_i,
  input  logic            req_write_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            req_ready_o,
  input  logic            iordy_i,
  input  logic [DW-1:0]   dd_i,
  output logic [DW-1:0]   dd_o,
  output logic            dd_oe_o,
  output logic            addr_valid_o,
  output logic            cmd_sel_o,
  output logic            rd_strobe_o,
  output logic            wr_strobe_o,
  output logic            done_o,
  output logic [DW-1:0]   rdata_o
);

  localparam int NUM_CLASS = 2;
  localparam int SYNC_LEN  = 2;

  logic [SYNC_LEN-1:0] rst_pipe_q;
  logic                rst_int_n;
  logic [TB_W-1:0]     tim_byte [NUM_CLASS];
  phase_len_t          class_len [NUM_CLASS];
  phase_len_t          sel_len;
  logic                iordy_en_w, byte_mode_w, narrow_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_LEN-1];

  pio_timing_regs #(
    .DATA_TIM_RST (DATA_TIM_RST),
    .CMD_TIM_RST  (CMD_TIM_RST)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_data_i  (cfg_data_i),
    .data_tim_o  (tim_byte[0]),
    .cmd_tim_o   (tim_byte[1]),
    .iordy_en_o  (iordy_en_w),
    .byte_mode_o (byte_mode_w)
  );

  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_dec
    pio_phase_decode u_dec (
      .tim_i (tim_byte[g]),
      .len_o (class_len[g])
    );
  end

  assign sel_len  = class_len[req_cmd_i];
  assign narrow_w = req_cmd_i || byte_mode_w;

  pio_cycle_seq #(.DW(DW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req_valid_i  (req_valid_i),
    .req_cmd_i    (req_cmd_i),
    .req_write_i  (req_write_i),
    .req_wdata_i  (req_wdata_i),
    .req_narrow_i (narrow_w),
    .len_i        (sel_len),
    .iordy_en_i   (iordy_en_w),
    .iordy_i      (iordy_i),
    .dd_i         (dd_i),
    .ready_o      (req_ready_o),
    .addr_valid_o (addr_valid_o),
    .cmd_sel_o    (cmd_sel_o),
    .rd_strobe_o  (rd_strobe_o),
    .wr_strobe_o  (wr_strobe_o),
    .dd_o         (dd_o),
    .dd_oe_o      (dd_oe_o),
    .done_o       (done_o),
    .rdata_o      (rdata_o)
  );

endmodule

// File: rtl/pio_strobe_gen_chk.sv
module pio_strobe_gen_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          addr_valid,
  input logic          rd_strobe,
  input logic          wr_strobe,
  input logic          done,
  input logic          dd_oe,
  input logic [DW-1:0] rdata,
  input logic          iordy_i,
  input logic          iordy_en
);

  logic strb;
  assign strb = rd_strobe || wr_strobe;

  // R3: never both strobes
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));

  // R2: first clock of an access is a setup clock
  a_r2_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> !strb);

  // R4: strobe only inside an addressed access
  a_r4_strobe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> addr_valid);

  // R6: done returns the block to ready on the next clock
  a_r6_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);

  // R6: no request accepted while an access is in flight
  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !ready);

  // R7: with stretching on, the strobe only ends after IORDY was seen high
  a_r7_iordy_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strb) && $past(iordy_en)) |-> $past(iordy_i));

  // R8: read data moves only when the read strobe ends
  a_r8_rdata_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != $past(rdata)) |-> $fell(rd_strobe));

  // R9: bus drive only within an access
  a_r9_oe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> (addr_valid && !rd_strobe));

endmodule

bind pio_strobe_gen pio_strobe_gen_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (req_ready_o),
  .addr_valid (addr_valid_o),
  .rd_strobe  (rd_strobe_o),
  .wr_strobe  (wr_strobe_o),
  .done       (done_o),
  .dd_oe      (dd_oe_o),
  .rdata      (rdata_o),
  .iordy_i    (iordy_i),
  .iordy_en   (iordy_en_w)
);

// File: tb/pio_strobe_gen_bench.sv
module pio_strobe_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_i;
  logic [1:0]    cfg_sel_i;
  logic [7:0]    cfg_data_i;
  logic          req_valid_i, req_cmd_i, req_write_i;
  logic [DW-1:0] req_wdata_i;
  logic          req_ready_o;
  logic          iordy_i;
  logic [DW-1:0] dd_i, dd_o, rdata_o;
  logic          dd_oe_o, addr_valid_o, cmd_sel_o, rd_strobe_o, wr_strobe_o, done_o;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  logic [7:0] m_data_tim = 8'hF5;
  logic [7:0] m_cmd_tim  = 8'hDE;
  bit         m_iordy    = 0;
  bit         m_byte     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_strobe_gen u_pio_strobe_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_i(cfg_wr_i), .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
    .req_valid_i(req_valid_i), .req_cmd_i(req_cmd_i), .req_write_i(req_write_i),
    .req_wdata_i(req_wdata_i), .req_ready_o(req_ready_o),
    .iordy_i(iordy_i), .dd_i(dd_i), .dd_o(dd_o), .dd_oe_o(dd_oe_o),
    .addr_valid_o(addr_valid_o), .cmd_sel_o(cmd_sel_o),
    .rd_strobe_o(rd_strobe_o), .wr_strobe_o(wr_strobe_o),
    .done_o(done_o), .rdata_o(rdata_o)
  );

  function automatic int b_setup(input logic [7:0] t);
    return int'(t[7:6]) + 1;
  endfunction

  function automatic int b_hold(input logic [7:0] t);
    case (t[5:3])
      3'd0: return 1;  3'd1: return 2;  3'd2: return 3;  3'd3: return 4;
      3'd4: return 5;  3'd5: return 6;  3'd6: return 8;  default: return 12;
    endcase
  endfunction

  function automatic int b_active(input logic [7:0] t);
    case (t[2:0])
      3'd0: return 2;  3'd1: return 3;  3'd2: return 4;  3'd3: return 5;
      3'd4: return 6;  3'd5: return 8;  3'd6: return 12; default: return 16;
    endcase
  endfunction

  function automatic logic [DW-1:0] b_mask(input logic [DW-1:0] w, input bit narrow);
    return narrow ? {8'h00, w[7:0]} : w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfg_wr_i = 1; cfg_sel_i = sel; cfg_data_i = val;
    @(negedge clk);
    cfg_wr_i = 0;
    case (sel)
      2'd0: m_data_tim = val;
      2'd1: m_cmd_tim  = val;
      default: begin m_iordy = val[0]; m_byte = val[1]; end
    endcase
  endtask

  // one access; ext = extra stretch clocks when IORDY stretching is on
  task automatic run_req(input bit cmd, input bit wr, input logic [DW-1:0] wd,
                         input logic [DW-1:0] rv, input int ext, input bit midcfg,
                         input string tag);
    logic [7:0] t;
    bit narrow;
    int es, ea, eh, s, a, h, n, dcnt;
    bit seen, done_bad, oe_bad, cls_bad, rd_ok;
    t = cmd ? m_cmd_tim : m_data_tim;
    narrow = cmd || m_byte;
    es = b_setup(t); ea = b_active(t) + (m_iordy ? ext : 0); eh = b_hold(t);
    s = 0; a = 0; h = 0; n = 0; dcnt = 0;
    seen = 0; done_bad = 0; oe_bad = 0; cls_bad = 0; rd_ok = wr;
    @(negedge clk);
    chk(req_ready_o === 1'b1, "R6 ready before request", int'(req_ready_o), 1);
    req_valid_i = 1; req_cmd_i = cmd; req_write_i = wr; req_wdata_i = wd;
    iordy_i = 0; dd_i = ~rv;
    forever begin
      @(negedge clk);
      req_valid_i = 0;
      cfg_wr_i = 0;
      n++;
      if (!addr_valid_o || n > 200) break;
      if (req_ready_o) done_bad = 1;
      if (cmd_sel_o !== cmd) cls_bad = 1;
      if (dd_oe_o !== wr) oe_bad = 1;
      if (wr && dd_o !== b_mask(wd, narrow)) oe_bad = 1;
      if (rd_strobe_o || wr_strobe_o) begin
        seen = 1; a++;
        if ((rd_strobe_o !== !wr) || (wr_strobe_o !== wr)) cls_bad = 1;
        if (done_o) done_bad = 1;
        dd_i = rv;
        if (m_iordy && a == ea) iordy_i = 1;
      end else if (!seen) begin
        s++;
        if (done_o) done_bad = 1;
        if (midcfg && s == 1) begin
          cfg_wr_i = 1; cfg_sel_i = 2'd0; cfg_data_i = 8'h00;
        end
      end else begin
        h++;
        if (h == 1 && !wr) begin
          rd_ok = (rdata_o === b_mask(rv, narrow));
          chk(rd_ok, {tag, " R8 read capture"}, int'(rdata_o), int'(b_mask(rv, narrow)));
          dd_i = ~rv;
        end
        if (done_o) begin dcnt++; if (h != eh) done_bad = 1; end
      end
    end
    iordy_i = 1;
    if (midcfg) m_data_tim = 8'h00;
    chk(s == es, {tag, " R2 setup clocks"}, s, es);
    chk(a == ea, {tag, (m_iordy ? " R7 stretched active clocks" : " R3 active clocks")}, a, ea);
    chk(h == eh, {tag, " R4 hold clocks"}, h, eh);
    chk(!done_bad && dcnt == 1, {tag, " R6 single done on last hold"}, dcnt, 1);
    chk(req_ready_o === 1'b1, {tag, " R6 ready after done"}, int'(req_ready_o), 1);
    chk(!oe_bad, {tag, " R9 write drive"}, int'(oe_bad), 0);
    chk(!cls_bad, {tag, " R5 class and strobe select"}, int'(cls_bad), 0);
    if (!wr) chk(rdata_o === b_mask(rv, narrow), {tag, " R8 rdata held"},
                 int'(rdata_o), int'(b_mask(rv, narrow)));
    if (midcfg) chk(s == es && a == ea && h == eh, {tag, " R10 timing snapshot"}, s + a + h, es + ea + eh);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst_n = 0; cfg_wr_i = 0; cfg_sel_i = 0; cfg_data_i = 0;
    req_valid_i = 0; req_cmd_i = 0; req_write_i = 0; req_wdata_i = 0;
    iordy_i = 1; dd_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(req_ready_o === 1'b1 && addr_valid_o === 1'b0, "R1 idle after reset", int'(req_ready_o), 1);
    chk(!rd_strobe_o && !wr_strobe_o && !done_o && !dd_oe_o, "R1 outputs low", int'(done_o), 0);
    chk(rdata_o === '0, "R1 rdata zero", int'(rdata_o), 0);

    // R1 defaults, R5 class selection
    run_req(0, 0, 16'h0, 16'hA55A, 0, 0, "R1 data default");
    run_req(1, 0, 16'h0, 16'h3CC3, 0, 0, "R1 cmd default");
    run_req(0, 1, 16'hBEEF, 16'h0, 0, 0, "R9 write 16");

    // R11 loading, shortest and longest lengths
    cfg_write(2'd0, 8'h00);
    run_req(0, 0, 16'h0, 16'h1234, 0, 0, "R11 data min");
    cfg_write(2'd1, 8'hFF);
    run_req(1, 1, 16'hCAFE, 16'h0, 0, 0, "R11 cmd max");
    run_req(0, 1, 16'h8001, 16'h0, 0, 0, "R5 data after cmd load");

    // R7 disabled: IORDY held low has no effect
    run_req(0, 0, 16'h0, 16'h5AA5, 3, 0, "R7 ignored");
    cfg_write(2'd2, 8'h01);
    run_req(0, 0, 16'h0, 16'h0F0F, 0, 0, "R7 no stretch");
    run_req(0, 0, 16'h0, 16'h7788, 5, 0, "R7 stretch");
    // R8/R9 narrow data port
    cfg_write(2'd2, 8'h02);
    run_req(0, 0, 16'h0, 16'hFEDC, 0, 0, "R8 byte read");
    run_req(0, 1, 16'hABCD, 16'h0, 0, 0, "R9 byte write");
    // R10 snapshot
    cfg_write(2'd0, 8'hC7);
    run_req(0, 0, 16'h0, 16'h4321, 0, 1, "R10 mid write");

    // constrained random
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 3 == 0) cfg_write(2'd0, 8'($urandom));
      if ($urandom % 3 == 0) cfg_write(2'd1, 8'($urandom));
      if ($urandom % 4 == 0) cfg_write(2'd2, 8'($urandom % 4));
      run_req(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
              int'($urandom % 4), 1'($urandom % 8 == 0), "rand");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule